// File: doc/BRIEF.md
# Buck Converter Fault Controller

This block sits between the PWM modulator of a fixed-frequency synchronous buck converter and its gate drivers. It takes the raw high-side request and decides, cycle by cycle, whether each gate may actually be driven. It enforces a maximum high-side on-time within each switching period. It drops single high-side pulses after a switching period in which the low-side over-current comparator fired. When over-current persists across several periods, or the output stays under-voltage long enough, it runs timed hiccup restarts. It shuts down for good on a thermal fault or on over-current that persists after the allowed number of restarts.

A strobe from the period timer marks the last clock cycle of each switching period. The block has four states. `ST_RUN` is normal switching. `ST_HICCUP` holds both gates off for `HICCUP_OFF_CYCLES` clocks. `ST_RESTART` is a single cycle that asks the soft-start sequencer to begin again. `ST_LATCHED` turns everything off until reset. The transitions are:
- RUN to HICCUP on an over-current trip while restarts remain, or on a qualified under-voltage.
- RUN to LATCHED on a trip once the restarts are used up.
- HICCUP to RESTART when the off-timer expires.
- RESTART to RUN.
- Any state to LATCHED on over-temperature.

Top module: `buck_fault_ctrl`

## Requirements
- R1: `hs_en` and `ls_en` are never high together. In `ST_RUN`, `ls_en` equals NOT(`hs_req` AND duty-allowed). The over-current skip does not affect `ls_en`.
- R2: In each period, `hs_en` can be high only in the first `MAX_ON_CYCLES` clocks after the clock that carried `period_strobe`. After reset, `hs_en` stays low until the first strobe.
- R3: An over-current event is `oc_hit` high on any clock of a period, including its strobe clock. Such an event holds `hs_en` low for the whole of the next period.
- R4: `hs_en` follows the request again in the period after any period that had no over-current event. A period with no event also resets the consecutive-event count.
- R5: When `OC_TRIP_COUNT` consecutive periods have an event, the block leaves `ST_RUN` at the strobe edge of the last of them. Both gates go low and a hiccup starts.
- R6: A hiccup keeps both gates low for `HICCUP_OFF_CYCLES` clocks. `restart_req` is then high for exactly one clock, and switching resumes on the next clock.
- R7: An over-current trip that occurs after `OC_HICCUP_LIMIT` over-current hiccups sets `latched_off` instead of starting a hiccup. While latched, `restart_req` never rises and both gates stay low.
- R8: Under-voltage is monitored only while `ss_done` is high in `ST_RUN`. It trips on the `UV_QUAL_CYCLES`-th consecutive clock with `uv_raw` high. A shorter run of `uv_raw` has no effect.
- R9: Under-voltage trips always start a hiccup, with no limit. They do not count toward the over-current restart limit.
- R10: `ot_flag` high on any clock sets `latched_off` on the next clock, from any state. The latch stays set after `ot_flag` falls.
- R11: Reset (`rst_n` low) returns the block to `ST_RUN` and clears the latch, the hiccup count and the event counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_strobe | input | 1 | High on the last clock of each switching period |
| hs_req | input | 1 | Raw high-side request from the modulator |
| oc_hit | input | 1 | Low-side over-current comparator, valid during low-side on-time |
| uv_raw | input | 1 | Output under-voltage comparator |
| ot_flag | input | 1 | Over-temperature flag |
| ss_done | input | 1 | Soft start finished |
| hs_en | output | 1 | Gated high-side enable |
| ls_en | output | 1 | Gated low-side enable |
| restart_req | output | 1 | One-clock request to restart soft start |
| latched_off | output | 1 | Permanent shutdown status |

## Verification
A wrong consecutive-event count shows up at the strobe edge that should or should not trip. Both gates then drop, or fail to drop, one clock later, well before the hiccup timer could hide it. A wrong hiccup count only becomes visible on a later trip, as a `latched_off` that comes a trip too early or too late. For that reason the over-current trips are run after several under-voltage restarts. An off-timer error moves the one-clock `restart_req` pulse by that many clocks, so the pulse's position is measured exactly.

// File: rtl/buck_fault_pkg.sv
package buck_fault_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HICCUP  = 2'd1,
        ST_RESTART = 2'd2,
        ST_LATCHED = 2'd3
    } fault_state_e;

endpackage

// File: rtl/bfc_duty_limit.sv
module bfc_duty_limit #(
    parameter int MAX_ON_CYCLES = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic period_strobe,
    output logic duty_ok
);
    localparam int CW = $clog2(MAX_ON_CYCLES + 1);
    localparam logic [CW-1:0] CAP = CW'(MAX_ON_CYCLES);

    logic [CW-1:0] on_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            on_cnt <= CAP;
        else if (period_strobe)
            on_cnt <= '0;
        else if (on_cnt != CAP)
            on_cnt <= on_cnt + 1'b1;
    end

    assign duty_ok = (on_cnt != CAP);
endmodule

// File: rtl/bfc_oc_tracker.sv
module bfc_oc_tracker #(
    parameter int OC_TRIP_COUNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic period_strobe,
    input  logic oc_hit,
    output logic skip_hs,
    output logic oc_trip
);
    localparam int CW = $clog2(OC_TRIP_COUNT + 1);
    localparam logic [CW-1:0] LAST = CW'(OC_TRIP_COUNT - 1);
    localparam logic [CW-1:0] TOP  = CW'(OC_TRIP_COUNT);

    logic          oc_seen;
    logic          skip_q;
    logic [CW-1:0] run_len;
    logic          had_event;

    assign had_event = oc_seen | oc_hit;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            oc_seen <= 1'b0;
            skip_q  <= 1'b0;
            run_len <= '0;
        end else if (period_strobe) begin
            oc_seen <= 1'b0;
            skip_q  <= had_event;
            if (!had_event)
                run_len <= '0;
            else if (run_len != TOP)
                run_len <= run_len + 1'b1;
        end else if (oc_hit) begin
            oc_seen <= 1'b1;
        end
    end

    assign skip_hs = skip_q;
    assign oc_trip = !clear && period_strobe && had_event && (run_len == LAST);
endmodule

// File: rtl/bfc_uv_qual.sv
module bfc_uv_qual #(
    parameter int UV_QUAL_CYCLES = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic uv_raw,
    output logic uv_trip
);
    localparam int CW = $clog2(UV_QUAL_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(UV_QUAL_CYCLES - 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !enable || !uv_raw)
            low_cnt <= '0;
        else if (low_cnt != LAST)
            low_cnt <= low_cnt + 1'b1;
    end

    assign uv_trip = enable && uv_raw && (low_cnt == LAST);
endmodule

// File: rtl/buck_fault_ctrl.sv
module buck_fault_ctrl
    import buck_fault_pkg::*;
#(
    parameter int MAX_ON_CYCLES     = 250,
    parameter int OC_TRIP_COUNT     = 4,
    parameter int OC_HICCUP_LIMIT   = 3,
    parameter int UV_QUAL_CYCLES    = 1250,
    parameter int HICCUP_OFF_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic period_strobe,
    input  logic hs_req,
    input  logic oc_hit,
    input  logic uv_raw,
    input  logic ot_flag,
    input  logic ss_done,
    output logic hs_en,
    output logic ls_en,
    output logic restart_req,
    output logic latched_off
);
    localparam int TW = $clog2(HICCUP_OFF_CYCLES + 1);
    localparam int HW = $clog2(OC_HICCUP_LIMIT + 1);
    localparam logic [TW-1:0] OFF_LAST  = TW'(HICCUP_OFF_CYCLES - 1);
    localparam logic [HW-1:0] HIC_LIMIT = HW'(OC_HICCUP_LIMIT);

    fault_state_e  state_q, state_d;
    logic [TW-1:0] off_tmr;
    logic [HW-1:0] oc_hiccups;
    logic          duty_ok, skip_hs, oc_trip, uv_trip, running;

    assign running = (state_q == ST_RUN);

    bfc_duty_limit #(.MAX_ON_CYCLES(MAX_ON_CYCLES)) duty_i (
        .clk(clk), .rst_n(rst_n), .period_strobe(period_strobe), .duty_ok(duty_ok)
    );

    bfc_oc_tracker #(.OC_TRIP_COUNT(OC_TRIP_COUNT)) oc_i (
        .clk(clk), .rst_n(rst_n), .clear(!running), .period_strobe(period_strobe),
        .oc_hit(oc_hit), .skip_hs(skip_hs), .oc_trip(oc_trip)
    );

    bfc_uv_qual #(.UV_QUAL_CYCLES(UV_QUAL_CYCLES)) uv_i (
        .clk(clk), .rst_n(rst_n), .enable(running && ss_done), .uv_raw(uv_raw),
        .uv_trip(uv_trip)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (ot_flag)
                    state_d = ST_LATCHED;
                else if (oc_trip)
                    state_d = (oc_hiccups == HIC_LIMIT) ? ST_LATCHED : ST_HICCUP;
                else if (uv_trip)
                    state_d = ST_HICCUP;
            end
            ST_HICCUP: begin
                if (ot_flag)
                    state_d = ST_LATCHED;
                else if (off_tmr == OFF_LAST)
                    state_d = ST_RESTART;
            end
            ST_RESTART: state_d = ot_flag ? ST_LATCHED : ST_RUN;
            ST_LATCHED: state_d = ST_LATCHED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    // hiccup off-timer and over-current restart count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_tmr    <= '0;
            oc_hiccups <= '0;
        end else begin
            off_tmr <= (state_q == ST_HICCUP) ? off_tmr + 1'b1 : '0;
            if (running && oc_trip && state_d == ST_HICCUP)
                oc_hiccups <= oc_hiccups + 1'b1;
        end
    end

    // outputs
    always_comb begin
        hs_en       = running && hs_req && duty_ok && !skip_hs;
        ls_en       = running && !(hs_req && duty_ok);
        restart_req = (state_q == ST_RESTART);
        latched_off = (state_q == ST_LATCHED);
    end
endmodule

// File: rtl/bfc_checker.sv
module bfc_checker (
    input logic clk,
    input logic rst_n,
    input logic ot_flag,
    input logic hs_en,
    input logic ls_en,
    input logic restart_req,
    input logic latched_off
);
    a_r1_gates_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    a_r6_restart_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !restart_req);

    a_r7_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        latched_off |=> latched_off);

    a_r7_latched_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        latched_off |-> (!hs_en && !ls_en && !restart_req));

    a_r10_ot_latches: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag |=> latched_off);
endmodule

bind buck_fault_ctrl bfc_checker chk_i (
    .clk(clk), .rst_n(rst_n), .ot_flag(ot_flag), .hs_en(hs_en), .ls_en(ls_en),
    .restart_req(restart_req), .latched_off(latched_off)
);

// File: tb/buck_fault_ctrl_tb.sv
`timescale 1ns/1ps
module buck_fault_ctrl_tb_top;
    localparam int P      = 10;
    localparam int MAXON  = 8;
    localparam int TRIPS  = 4;
    localparam int HLIM   = 3;
    localparam int UVQ    = 8;
    localparam int OFF    = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic period_strobe = 1'b0, hs_req = 1'b0, oc_hit = 1'b0;
    logic uv_raw = 1'b0, ot_flag = 1'b0, ss_done = 1'b0;
    logic hs_en, ls_en, restart_req, latched_off;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    buck_fault_ctrl #(
        .MAX_ON_CYCLES(MAXON), .OC_TRIP_COUNT(TRIPS), .OC_HICCUP_LIMIT(HLIM),
        .UV_QUAL_CYCLES(UVQ), .HICCUP_OFF_CYCLES(OFF)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .period_strobe(period_strobe), .hs_req(hs_req),
        .oc_hit(oc_hit), .uv_raw(uv_raw), .ot_flag(ot_flag), .ss_done(ss_done),
        .hs_en(hs_en), .ls_en(ls_en), .restart_req(restart_req),
        .latched_off(latched_off)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // sample i of a period sees the request driven at i-1 (mod P)
    function automatic int exp_hs(input int duty);
        int c = 0;
        for (int i = 0; i < P; i++)
            if (((i + P - 1) % P) < duty && i < MAXON) c++;
        return c;
    endfunction

    function automatic int exp_ls(input int duty);
        return P - exp_hs(duty);
    endfunction

    task automatic run_period(input int duty, input int oc_pos,
                              output int hs_cnt, output int ls_cnt);
        hs_cnt = 0;
        ls_cnt = 0;
        for (int i = 0; i < P; i++) begin
            @(negedge clk);
            hs_cnt += int'(hs_en);
            ls_cnt += int'(ls_en);
            hs_req        = (i < duty);
            period_strobe = (i == P - 1);
            oc_hit        = (i == oc_pos);
        end
    endtask

    // counts clocks from a trip edge until restart_req is seen
    task automatic wait_restart(output int k, output int gates_at1);
        k = 0;
        gates_at1 = 0;
        do begin
            @(negedge clk);
            k++;
            if (k == 1) gates_at1 = int'(hs_en) + int'(ls_en);
            uv_raw = 1'b0;
            period_strobe = 1'b0;
            oc_hit = 1'b0;
            hs_req = 1'b0;
        end while (!restart_req && k < 200);
    endtask

    task automatic quiet_restart_count(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            seen += int'(restart_req);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        period_strobe = 1'b0; hs_req = 1'b0; oc_hit = 1'b0;
        uv_raw = 1'b0; ot_flag = 1'b0; ss_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic uv_trip_once(output int k, output int g);
        for (int i = 0; i < UVQ; i++) begin
            @(negedge clk);
            uv_raw = 1'b1;
        end
        wait_restart(k, g);
    endtask

    task automatic oc_trip_once(output int k, output int g);
        int h, l;
        run_period(5, -1, h, l);   // resync after restart
        for (int j = 0; j < TRIPS; j++) run_period(5, 3, h, l);
        wait_restart(k, g);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int h, l, k, g, seen;
        do_reset();
        @(negedge clk);
        // R11 / R2: reset state
        chk("R11 latched after reset", int'(latched_off), 0);
        chk("R11 restart after reset", int'(restart_req), 0);
        chk("R2 hs before first strobe", int'(hs_en), 0);
        chk("R1 ls in run with no request", int'(ls_en), 1);

        // R1 / R2: full duty sweep
        for (int d = 0; d <= P; d++) begin
            run_period(d, -1, h, l);
            run_period(d, -1, h, l);
            chk($sformatf("R2 hs count duty=%0d", d), h, exp_hs(d));
            chk($sformatf("R1 ls count duty=%0d", d), l, exp_ls(d));
        end
        run_period(5, -1, h, l);

        // R3 / R4: single events at several positions, including the strobe clock
        for (int pos = 0; pos < P; pos += 3) begin
            run_period(5, pos, h, l);
            run_period(5, -1, h, l);
            chk($sformatf("R3 skipped hs pos=%0d", pos), h, 0);
            chk($sformatf("R3 ls unaffected pos=%0d", pos), l, exp_ls(5));
            run_period(5, -1, h, l);
            chk($sformatf("R4 hs resumes pos=%0d", pos), h, exp_hs(5));
        end

        // R4 / R5: runs shorter than the trip length, broken by clean periods
        for (int n = 1; n < TRIPS; n++) begin
            for (int j = 0; j < n; j++) run_period(5, 2, h, l);
            run_period(5, -1, h, l);
            chk($sformatf("R3 last of run n=%0d skipped", n), h, 0);
            run_period(5, -1, h, l);
            chk($sformatf("R4 no trip after run n=%0d", n), h, exp_hs(5));
        end
        for (int j = 0; j < TRIPS - 1; j++) run_period(5, 2, h, l);
        run_period(5, -1, h, l);
        for (int j = 0; j < TRIPS - 1; j++) run_period(5, 2, h, l);
        run_period(5, -1, h, l);
        run_period(5, -1, h, l);
        chk("R4 counter cleared between runs", h, exp_hs(5));
        chk("R5 no latch between runs", int'(latched_off), 0);

        // R8: short under-voltage runs and monitoring gated by soft start
        ss_done = 1'b1;
        for (int i = 0; i < UVQ - 1; i++) begin
            @(negedge clk);
            uv_raw = 1'b1;
            hs_req = 1'b0;
        end
        @(negedge clk);
        uv_raw = 1'b0;
        @(negedge clk);
        chk("R8 short uv run ignored", int'(ls_en), 1);
        ss_done = 1'b0;
        for (int i = 0; i < 3 * UVQ; i++) begin
            @(negedge clk);
            uv_raw = 1'b1;
        end
        @(negedge clk);
        uv_raw = 1'b0;
        chk("R8 uv ignored before soft start", int'(ls_en), 1);
        quiet_restart_count(30, seen);
        chk("R8 no restart before soft start", seen, 0);
        ss_done = 1'b1;

        // R6 / R8 / R9: repeated under-voltage hiccups
        for (int t = 0; t < 5; t++) begin
            uv_trip_once(k, g);
            chk($sformatf("R8 uv trip gates off t=%0d", t), g, 0);
            chk($sformatf("R6 restart timing uv t=%0d", t), k, OFF + 1);
            @(negedge clk);
            chk($sformatf("R6 restart one clock t=%0d", t), int'(restart_req), 0);
            chk($sformatf("R9 running after uv t=%0d", t), int'(ls_en), 1);
        end
        chk("R9 uv never latches", int'(latched_off), 0);

        // R5 / R6 / R7: over-current trips
        for (int t = 0; t < HLIM; t++) begin
            oc_trip_once(k, g);
            chk($sformatf("R5 oc trip gates off t=%0d", t), g, 0);
            chk($sformatf("R6 restart timing oc t=%0d", t), k, OFF + 1);
            chk($sformatf("R7 not latched t=%0d", t), int'(latched_off), 0);
        end
        run_period(5, -1, h, l);
        for (int j = 0; j < TRIPS; j++) run_period(5, 3, h, l);
        quiet_restart_count(3 * OFF, seen);
        chk("R7 latched after limit", int'(latched_off), 1);
        chk("R7 no restart when latched", seen, 0);
        run_period(5, -1, h, l);
        chk("R7 gates off when latched", h + l, 0);

        // R11: reset releases the latch
        do_reset();
        @(negedge clk);
        chk("R11 latch cleared", int'(latched_off), 0);
        chk("R11 running again", int'(ls_en), 1);
        ss_done = 1'b1;

        // R10: over-temperature while running
        @(negedge clk);
        ot_flag = 1'b1;
        @(negedge clk);
        ot_flag = 1'b0;
        chk("R10 ot latches", int'(latched_off), 1);
        quiet_restart_count(10, seen);
        chk("R10 latch persists", int'(latched_off), 1);
        chk("R10 gates off", int'(hs_en) + int'(ls_en), 0);

        // R10: over-temperature during a hiccup
        do_reset();
        ss_done = 1'b1;
        for (int i = 0; i < UVQ; i++) begin
            @(negedge clk);
            uv_raw = 1'b1;
        end
        repeat (5) begin
            @(negedge clk);
            uv_raw = 1'b0;
        end
        ot_flag = 1'b1;
        @(negedge clk);
        ot_flag = 1'b0;
        chk("R10 ot latches in hiccup", int'(latched_off), 1);
        quiet_restart_count(2 * OFF, seen);
        chk("R10 no restart after ot", seen, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule